// File: doc/BRIEF.md
# Partial-Decode I/O Port Selector

This block sits on an 8-bit isolated I/O bus and turns the processor's active-low request, read and write strobes into port accesses. An OUT access is an I/O request together with a write strobe, and an IN access is an I/O request together with a read strobe. The block does not fully decode the port address. Each port watches one address bit and is chosen whenever that bit is low. As a result, many addresses reach the same port, and one access can reach several ports at the same time.

On the output side, an 8-bit latch is divided into `SEGMENTS` equal slices: one slice of 8 bits, two of 4 bits, or four of 2 bits. Slice k answers to address bit k. A slice takes the write data on every clock while it is selected and keeps its value once it is no longer selected. On the input side, a switch word is placed on the read bus, with an output-enable flag, only while an IN access has the input port's select bit low. An input port and an output port can therefore share an address, and only the kind of access tells them apart.

Top module: `iop_port_selector`

## Requirements
- R1: While `rst` is high at a clock edge, every latch slice is cleared to 0 after that edge. `rd_oe` is 0 whenever no IN access is present.
- R2: The output latches change only on an OUT access, which requires `iorq_n`=0 and `wr_n`=0. With either of these high, the latches keep their value.
- R3: `rd_oe` can be 1 only when `iorq_n`=0 and `rd_n`=0.
- R4: With `SEGMENTS`=1, an OUT access with address bit 0 low loads all 8 data bits. Bits 1 to 7 are ignored, so address 0xFE also loads the latch.
- R5: Each slice behaves as a level latch. While it stays selected over consecutive clocks, it follows the write data one clock later. After deselection it holds the last value it took.
- R6: Slice k covers `port_q` bits [k*W +: W], where W = 8/`SEGMENTS`, and is selected by address bit k = 0. An unselected slice is unchanged. With `SEGMENTS`=2, address 0x01 loads only bits 7:4.
- R7: If an OUT access has several select bits low, every matching slice loads from the same access, in the same clock.
- R8: During an IN access with address bit `IN_SEL_BIT` (default 0) low, `rd_oe`=1 and `rd_data` equals `in_sw` in the same cycle. Otherwise `rd_oe`=0 and `rd_data`=0.
- R9: An IN access leaves every latch unchanged, even at an address that also selects output slices. An OUT access never raises `rd_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iorq_n | input | 1 | I/O request strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 8 | Port address |
| wdata | input | 8 | Data driven by the processor on OUT |
| in_sw | input | 8 | Switch word offered by the input port |
| port_q | output | 8 | Output latch contents, slice k in bits [k*W +: W] |
| rd_data | output | 8 | Input port data onto the bus, 0 when released |
| rd_oe | output | 1 | Input port is driving the bus |

## Verification
Two latch slices can load in the same clock when the OUT address has more than one select bit low. Under partial decode, the input port and an output slice can also answer to the same address. The bench sweeps all 256 addresses, applying an OUT and then an IN access at each one. It runs three instances at once, one for each split, and compares every slice against a model that computes the expected value bit by bit from the address. For each address it also checks that the input port enables only on IN, that the latches do not move on IN, and that the processor and the port never drive the bus together.

// File: rtl/iop_pkg.sv
package iop_pkg;

    typedef struct packed {
        logic is_in;
        logic is_out;
    } iop_qual_t;

    function automatic iop_qual_t decode_strobes(input logic iorq_n,
                                                 input logic rd_n,
                                                 input logic wr_n);
        iop_qual_t q;
        q.is_in  = !iorq_n && !rd_n;
        q.is_out = !iorq_n && !wr_n;
        return q;
    endfunction

    function automatic int unsigned slice_width(input int unsigned data_w,
                                                input int unsigned segs);
        return data_w / segs;
    endfunction

endpackage

// File: rtl/iop_strobe_decode.sv
module iop_strobe_decode
    import iop_pkg::*;
(
    input  logic      iorq_n,
    input  logic      rd_n,
    input  logic      wr_n,
    output iop_qual_t qual
);
    always_comb qual = decode_strobes(iorq_n, rd_n, wr_n);
endmodule

// File: rtl/iop_latch_bank.sv
module iop_latch_bank
    import iop_pkg::*;
#(
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned SEGMENTS = 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                is_out,
    input  logic [SEGMENTS-1:0] sel_n,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   q
);
    localparam int unsigned SEG_W = slice_width(DATA_W, SEGMENTS);

    for (genvar k = 0; k < SEGMENTS; k++) begin : g_slice
        logic             load;
        logic [SEG_W-1:0] hold;
        assign load = is_out && !sel_n[k];
        always_ff @(posedge clk) begin
            if (rst)       hold <= '0;
            else if (load) hold <= wdata[k*SEG_W +: SEG_W];
        end
        assign q[k*SEG_W +: SEG_W] = hold;
    end
endmodule

// File: rtl/iop_in_port.sv
module iop_in_port #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              is_in,
    input  logic              sel_n,
    input  logic [DATA_W-1:0] sw,
    output logic [DATA_W-1:0] bus_data,
    output logic              bus_oe
);
    always_comb begin
        bus_oe   = is_in && !sel_n;
        bus_data = bus_oe ? sw : '0;
    end
endmodule

// File: rtl/iop_port_selector.sv
module iop_port_selector
    import iop_pkg::*;
#(
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned SEGMENTS   = 1,
    parameter int unsigned IN_SEL_BIT = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              iorq_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] in_sw,
    output logic [DATA_W-1:0] port_q,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_oe
);
    iop_qual_t qual;

    iop_strobe_decode u_dec (
        .iorq_n (iorq_n),
        .rd_n   (rd_n),
        .wr_n   (wr_n),
        .qual   (qual)
    );

    iop_latch_bank #(.DATA_W(DATA_W), .SEGMENTS(SEGMENTS)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .is_out (qual.is_out),
        .sel_n  (addr[SEGMENTS-1:0]),
        .wdata  (wdata),
        .q      (port_q)
    );

    iop_in_port #(.DATA_W(DATA_W)) u_in (
        .is_in    (qual.is_in),
        .sel_n    (addr[IN_SEL_BIT]),
        .sw       (in_sw),
        .bus_data (rd_data),
        .bus_oe   (rd_oe)
    );
endmodule

// File: rtl/iop_port_selector_chk.sv
module iop_port_selector_chk #(
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned SEGMENTS   = 1,
    parameter int unsigned IN_SEL_BIT = 0
) (
    input logic              clk,
    input logic              rst,
    input logic              iorq_n,
    input logic              rd_n,
    input logic              wr_n,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] in_sw,
    input logic [DATA_W-1:0] port_q,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_oe
);
    localparam int unsigned SEG_W = DATA_W / SEGMENTS;

    // R1
    reset_clears_chk: assert property (@(posedge clk) rst |=> port_q == '0);

    // R3
    oe_needs_read_chk: assert property (@(posedge clk) disable iff (rst)
        rd_oe |-> (!iorq_n && !rd_n));

    // R8
    oe_data_match_chk: assert property (@(posedge clk) disable iff (rst)
        rd_oe |-> rd_data == in_sw);

    // R8
    released_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_oe |-> rd_data == '0);

    for (genvar k = 0; k < SEGMENTS; k++) begin : g_seg
        // R6
        slice_load_chk: assert property (@(posedge clk) disable iff (rst)
            (!iorq_n && !wr_n && !addr[k]) |=>
                port_q[k*SEG_W +: SEG_W] == $past(wdata[k*SEG_W +: SEG_W]));
        // R2
        slice_hold_chk: assert property (@(posedge clk) disable iff (rst)
            !(!iorq_n && !wr_n && !addr[k]) |=> $stable(port_q[k*SEG_W +: SEG_W]));
    end
endmodule

bind iop_port_selector iop_port_selector_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEGMENTS(SEGMENTS), .IN_SEL_BIT(IN_SEL_BIT)
) u_chk (.*);

// File: tb/iop_port_selector_bench.sv
module iop_port_selector_bench;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst;
    logic iorq_n, rd_n, wr_n;
    logic [7:0] addr, wdata, in_sw;
    logic [7:0] q1, q2, q4, rd1, rd2, rd4;
    logic oe1, oe2, oe4;
    logic [7:0] e1, e2, e4;
    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    iop_port_selector #(.SEGMENTS(1)) u_iop_port_selector_s1 (
        .clk(clk), .rst(rst), .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .wdata(wdata), .in_sw(in_sw),
        .port_q(q1), .rd_data(rd1), .rd_oe(oe1));
    iop_port_selector #(.SEGMENTS(2)) u_iop_port_selector (
        .clk(clk), .rst(rst), .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .wdata(wdata), .in_sw(in_sw),
        .port_q(q2), .rd_data(rd2), .rd_oe(oe2));
    iop_port_selector #(.SEGMENTS(4)) u_iop_port_selector_s4 (
        .clk(clk), .rst(rst), .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .wdata(wdata), .in_sw(in_sw),
        .port_q(q4), .rd_data(rd4), .rd_oe(oe4));

    function automatic logic [7:0] model(input logic [7:0] prev, input int segs,
                                         input logic [7:0] a, input logic [7:0] d);
        logic [7:0] r;
        int w;
        r = prev;
        w = 8 / segs;
        for (int k = 0; k < segs; k++)
            if (!a[k])
                for (int b = 0; b < w; b++) r[k*w + b] = d[k*w + b];
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_q(input string req);
        chk({req, " s1"}, {24'd0, q1}, {24'd0, e1});
        chk({req, " s2"}, {24'd0, q2}, {24'd0, e2});
        chk({req, " s4"}, {24'd0, q4}, {24'd0, e4});
    endtask

    task automatic check_bus(input string req, input logic en, input logic [7:0] sw);
        logic [7:0] ed;
        ed = en ? sw : 8'h00;
        chk({req, " oe1"}, {31'd0, oe1}, {31'd0, en});
        chk({req, " oe4"}, {31'd0, oe4}, {31'd0, en});
        chk({req, " rd2"}, {24'd0, rd2}, {24'd0, ed});
        // processor drives the bus on OUT; both drivers must never be on
        chk({req, " contention"}, {31'd0, oe2 && !iorq_n && !wr_n}, 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        if (!finished) begin
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1; iorq_n = 1; rd_n = 1; wr_n = 1;
        addr = 8'hFF; wdata = 8'h00; in_sw = 8'h00;
        e1 = 0; e2 = 0; e4 = 0;
        repeat (2) @(posedge clk);
        #1;
        check_q("R1 reset");
        check_bus("R1 idle", 1'b0, in_sw);
        @(negedge clk) rst = 0;

        // R2 / R3: strobe combinations, never read and write together
        for (int s = 0; s < 8; s++) begin
            logic io, rd, wr;
            {io, rd, wr} = 3'(s);
            if (!io && !rd && !wr) continue;
            @(negedge clk);
            iorq_n = io; rd_n = rd; wr_n = wr;
            addr = 8'h00; wdata = 8'h3C + 8'(s); in_sw = 8'hC3 ^ 8'(s);
            #1;
            check_bus("R3 strobes", !io && !rd, in_sw);
            @(posedge clk); #1;
            if (!io && !wr) begin
                e1 = model(e1, 1, addr, wdata);
                e2 = model(e2, 2, addr, wdata);
                e4 = model(e4, 4, addr, wdata);
            end
            check_q("R2 strobes");
        end
        @(negedge clk) begin iorq_n = 1; rd_n = 1; wr_n = 1; end

        // R4 R6 R7 R8 R9: full address sweep, OUT then IN
        for (int a = 0; a < 256; a++) begin
            logic [7:0] av;
            av = 8'(a);
            @(negedge clk);
            iorq_n = 0; wr_n = 0; rd_n = 1; addr = av;
            wdata = (av * 8'd37) ^ 8'h5A; in_sw = ~av;
            #1;
            check_bus("R9 out no oe", 1'b0, in_sw);
            @(posedge clk); #1;
            e1 = model(e1, 1, av, wdata);
            e2 = model(e2, 2, av, wdata);
            e4 = model(e4, 4, av, wdata);
            chk("R4 8-bit latch", {24'd0, q1}, {24'd0, e1});
            chk("R6 nibble slices", {24'd0, q2}, {24'd0, e2});
            if ($countones(~av[3:0]) > 1)
                chk("R7 multi-slice", {24'd0, q4}, {24'd0, e4});
            else
                chk("R6 pair slices", {24'd0, q4}, {24'd0, e4});
            @(negedge clk);
            wr_n = 1; rd_n = 0; wdata = ~wdata;
            #1;
            check_bus("R8 input port", !av[0], in_sw);
            @(posedge clk); #1;
            check_q("R9 in leaves latch");
            @(negedge clk) begin iorq_n = 1; rd_n = 1; end
        end

        // R5: selection held over several clocks, then released
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            iorq_n = 0; wr_n = 0; addr = 8'hF0; wdata = 8'h11 * 8'(c + 3);
            @(posedge clk); #1;
            e1 = wdata; e2 = wdata; e4 = wdata;
            check_q("R5 follow");
        end
        @(negedge clk);
        iorq_n = 1; wr_n = 1; wdata = 8'hE7;
        @(posedge clk); #1;
        check_q("R5 hold");

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule